// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block is a bank of down-counting timers that all advance from one shared prescaler. The prescaler counts down on every clock. When it reaches zero it reloads from its own reload register and emits a single tick, and that tick steps every enabled timer by one. Each timer can run once and stop at zero, or reload itself and repeat. Software can force a load from the reload register. When a timer underflows, it can latch a pending flag and request an interrupt.

Software reaches the bank through a simple word-addressed register port. Reads return one cycle after the request. A read-only configuration word reports the number of timers, the first interrupt line used and how interrupts are routed. Interrupts go either to one shared line or to one line per timer, counted up from a base line. A write to a timer's value or control word in the same cycle as a tick takes precedence over that tick for that timer.

Top module: `tick_timer_bank`

## Requirements
- R1: The word address map is: 0 prescaler count, 1 prescaler reload, 2 configuration, 3 reserved. Timer i occupies words 4+4i (count), 5+4i (reload), 6+4i (control) and 7+4i (reserved). The configuration word holds the timer count modulo 8 in bits 2:0, the base interrupt line in bits 7:3 and, in bit 8, a one for per-timer lines or a zero for one shared line.
- R2: After reset every count, reload and control register reads as zero and all interrupt lines are low.
- R3: The prescaler count drops by one each clock. At zero it reloads from the prescaler reload register and issues one tick, so ticks come every reload+1 clocks. A written prescaler count reads back and suppresses the tick of that cycle.
- R4: Control bit 0 enables a timer, which then drops by one per tick. With bit 0 clear the count holds.
- R5: A tick that finds an enabled count at zero is an underflow. After a timer is loaded with R and the prescaler is aligned with reload P, the first underflow comes (R+1)*(P+1) clocks later.
- R6: With control bit 1 set, an underflow reloads the count from the timer's reload register, and underflows repeat every (R+1)*(P+1) clocks.
- R7: With control bit 1 clear, the count stays at zero after the underflow and the timer clears its own enable bit.
- R8: Writing control bit 2 as one copies the reload register into the count. Writing it as zero leaves the count unchanged. Bit 2 always reads as zero.
- R9: Control bit 3 enables interrupts. An underflow with bit 3 set sets pending bit 4. Writing bit 4 as one clears it, and writing it as zero leaves it set.
- R10: An underflow with bit 3 clear sets no pending flag and raises no interrupt, but still reloads or stops the timer.
- R11: An interrupting underflow raises a registered one-cycle pulse in the following cycle. The pulse goes on line base+i in per-timer mode, or on line base in shared mode. No other line is ever driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after a read request |
| irq_o | output | IRQW | Interrupt lines |

## Verification
The bench sweeps every timer across several prescaler reloads and timer reloads, in both one-shot and auto-reload modes. It compares the exact clock of each interrupt pulse against (R+1)*(P+1), on a per-timer instance and on a shared-line instance at once. An off-by-one in the prescaler or in the zero test would move the pulse by a clock or a whole tick. Wrong routing would light the wrong line. A one-shot timer that fails to stop would pulse again in the second window. Separate checks cover the load strobe (it must copy the reload and read back as zero), pending clear-on-one versus keep-on-zero, and an interrupt-disabled underflow. That last case must still stop the timer but must leave no pending flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // control word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_RL   = 1;
  localparam int CB_LD   = 2;
  localparam int CB_IE   = 3;
  localparam int CB_PEND = 4;

  // word offsets in the global slot
  localparam logic [1:0] GW_PSC  = 2'd0;
  localparam logic [1:0] GW_PRLD = 2'd1;
  localparam logic [1:0] GW_CFG  = 2'd2;

  // word offsets in a channel slot
  localparam logic [1:0] CW_VAL = 2'd0;
  localparam logic [1:0] CW_RLD = 2'd1;
  localparam logic [1:0] CW_CTL = 2'd2;

  typedef struct packed {
    logic pend;
    logic ie;
    logic rl;
    logic en;
  } chan_ctl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          val_we_i,
  input  logic          rld_we_i,
  input  logic [PW-1:0] wdata_i,
  output logic [PW-1:0] val_o,
  output logic [PW-1:0] rld_o,
  output logic          tick_o
);
  logic [PW-1:0] val_q;
  logic [PW-1:0] rld_q;

  // a bus write to the count replaces the tick of that cycle
  assign tick_o = (val_q == '0) && !val_we_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      rld_q <= '0;
    end else begin
      if (rld_we_i) rld_q <= wdata_i;
      if (val_we_i)      val_q <= wdata_i;
      else if (tick_o)   val_q <= rld_q;
      else               val_q <= val_q - 1'b1;
    end
  end

  assign val_o = val_q;
  assign rld_o = rld_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          val_we_i,
  input  logic          rld_we_i,
  input  logic          ctl_we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] rld_o,
  output chan_ctl_t     ctl_o,
  output logic          irq_req_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] rld_q;
  chan_ctl_t     ctl_q;
  logic          step;
  logic          at_zero;

  assign at_zero   = (cnt_q == '0);
  assign step      = tick_i && ctl_q.en && !val_we_i && !ctl_we_i;
  assign irq_req_o = step && at_zero && ctl_q.ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
      ctl_q <= '0;
    end else begin
      if (rld_we_i) rld_q <= wdata_i;
      if (ctl_we_i) begin
        ctl_q.en   <= wdata_i[CB_EN];
        ctl_q.rl   <= wdata_i[CB_RL];
        ctl_q.ie   <= wdata_i[CB_IE];
        ctl_q.pend <= ctl_q.pend && !wdata_i[CB_PEND];
        if (wdata_i[CB_LD]) cnt_q <= rld_q;
      end else if (val_we_i) begin
        cnt_q <= wdata_i;
      end else if (step) begin
        if (at_zero) begin
          if (ctl_q.rl) cnt_q    <= rld_q;
          else          ctl_q.en <= 1'b0;
          if (ctl_q.ie) ctl_q.pend <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign ctl_o = ctl_q;
endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route #(
  parameter int N_TMR    = 4,
  parameter int IRQW     = 16,
  parameter int IRQ_BASE = 3,
  parameter int SEP_IRQ  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_TMR-1:0] req_i,
  output logic [IRQW-1:0]  irq_o
);
  logic [IRQW-1:0] line_d;
  logic [IRQW-1:0] line_q;

  generate
    if (SEP_IRQ != 0) begin : g_sep
      always_comb begin
        line_d = '0;
        for (int i = 0; i < N_TMR; i++) line_d[IRQ_BASE+i] = req_i[i];
      end
    end else begin : g_shared
      always_comb begin
        line_d = '0;
        line_d[IRQ_BASE] = |req_i;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= line_d;
  end

  assign irq_o = line_q;
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int N_TMR    = 4,
  parameter int DW       = 32,
  parameter int CW       = 32,
  parameter int PW       = 32,
  parameter int AW       = 6,
  parameter int IRQW     = 16,
  parameter int IRQ_BASE = 3,
  parameter int SEP_IRQ  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [IRQW-1:0] irq_o
);
  localparam int SW = AW - 2;
  localparam logic [DW-1:0] CFG_WORD =
    (DW'(SEP_IRQ != 0) << 8) | (DW'(IRQ_BASE) << 3) | DW'(N_TMR % 8);

  logic          wr;
  logic          rd;
  logic [SW-1:0] slot;
  logic [1:0]    sub;
  logic          glob;

  assign wr   = bus_req && bus_we;
  assign rd   = bus_req && !bus_we;
  assign slot = bus_addr[AW-1:2];
  assign sub  = bus_addr[1:0];
  assign glob = (slot == '0);

  logic          psc_val_we;
  logic          psc_rld_we;
  logic [PW-1:0] psc_val;
  logic [PW-1:0] psc_rld;
  logic          tick;

  assign psc_val_we = wr && glob && (sub == GW_PSC);
  assign psc_rld_we = wr && glob && (sub == GW_PRLD);

  tmr_prescaler #(.PW(PW)) psc_i (
    .clk      (clk),
    .rst      (rst),
    .val_we_i (psc_val_we),
    .rld_we_i (psc_rld_we),
    .wdata_i  (bus_wdata[PW-1:0]),
    .val_o    (psc_val),
    .rld_o    (psc_rld),
    .tick_o   (tick)
  );

  logic [CW-1:0]       cnt_a [N_TMR];
  logic [CW-1:0]       rld_a [N_TMR];
  chan_ctl_t           ctl_a [N_TMR];
  logic [N_TMR-1:0]    irq_req;
  logic [N_TMR-1:0]    en_v;
  logic [N_TMR-1:0]    ie_v;
  logic [N_TMR-1:0]    pend_v;
  logic [N_TMR*CW-1:0] cnt_flat;

  generate
    for (genvar i = 0; i < N_TMR; i++) begin : g_ch
      logic hit;
      assign hit = wr && (slot == SW'(i + 1));

      tmr_channel #(.CW(CW)) ch_i (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .val_we_i  (hit && (sub == CW_VAL)),
        .rld_we_i  (hit && (sub == CW_RLD)),
        .ctl_we_i  (hit && (sub == CW_CTL)),
        .wdata_i   (bus_wdata[CW-1:0]),
        .cnt_o     (cnt_a[i]),
        .rld_o     (rld_a[i]),
        .ctl_o     (ctl_a[i]),
        .irq_req_o (irq_req[i])
      );

      assign en_v[i]   = ctl_a[i].en;
      assign ie_v[i]   = ctl_a[i].ie;
      assign pend_v[i] = ctl_a[i].pend;
      assign cnt_flat[i*CW +: CW] = cnt_a[i];
    end
  endgenerate

  tmr_irq_route #(
    .N_TMR    (N_TMR),
    .IRQW     (IRQW),
    .IRQ_BASE (IRQ_BASE),
    .SEP_IRQ  (SEP_IRQ)
  ) route_i (
    .clk   (clk),
    .rst   (rst),
    .req_i (irq_req),
    .irq_o (irq_o)
  );

  // read path
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_q;

  always_comb begin
    rd_mux = '0;
    if (glob) begin
      case (sub)
        GW_PSC:  rd_mux = DW'(psc_val);
        GW_PRLD: rd_mux = DW'(psc_rld);
        GW_CFG:  rd_mux = CFG_WORD;
        default: rd_mux = '0;
      endcase
    end else begin
      for (int i = 0; i < N_TMR; i++) begin
        if (slot == SW'(i + 1)) begin
          case (sub)
            CW_VAL:  rd_mux = DW'(cnt_a[i]);
            CW_RLD:  rd_mux = DW'(rld_a[i]);
            CW_CTL:  rd_mux = DW'({ctl_a[i].pend, ctl_a[i].ie, 1'b0,
                                   ctl_a[i].rl, ctl_a[i].en});
            default: rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk #(
  parameter int N_TMR    = 4,
  parameter int CW       = 32,
  parameter int PW       = 32,
  parameter int AW       = 6,
  parameter int IRQW     = 16,
  parameter int IRQ_BASE = 3,
  parameter int SEP_IRQ  = 1
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_req,
  input logic                bus_we,
  input logic [AW-1:0]       bus_addr,
  input logic                rd_ld_bit,
  input logic [IRQW-1:0]     irq_o,
  input logic [PW-1:0]       psc_val,
  input logic [PW-1:0]       psc_rld,
  input logic [N_TMR-1:0]    en_v,
  input logic [N_TMR-1:0]    ie_v,
  input logic [N_TMR-1:0]    pend_v,
  input logic [N_TMR*CW-1:0] cnt_flat
);
  localparam logic [IRQW-1:0] LINE_MASK = (SEP_IRQ != 0) ?
    IRQW'(((1 << N_TMR) - 1) << IRQ_BASE) : IRQW'(1 << IRQ_BASE);

  logic psc_wr;
  logic rd_ctl;
  assign psc_wr = bus_req && bus_we && (bus_addr == '0);
  assign rd_ctl = bus_req && !bus_we && (bus_addr[AW-1:2] != '0) &&
                  (bus_addr[1:0] == 2'd2);

  // R11
  line_range_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq_o & ~LINE_MASK) == '0));

  // R3
  psc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (psc_val != '0 && !psc_wr) |=> (psc_val == $past(psc_val) - 1'b1));

  // R3
  psc_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (psc_val == '0 && !psc_wr) |=> (psc_val == $past(psc_rld)));

  // R9
  pend_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_v & ~$past(pend_v) & ~$past(ie_v)) == '0));

  // R8
  ld_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_ctl |=> !rd_ld_bit);

  generate
    for (genvar i = 0; i < N_TMR; i++) begin : g_hold
      logic wr_ch;
      assign wr_ch = bus_req && bus_we && (bus_addr[AW-1:2] == (AW-2)'(i + 1));
      // R4
      hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_v[i] && !wr_ch) |=> (cnt_flat[i*CW +: CW] == $past(cnt_flat[i*CW +: CW])));
    end
  endgenerate
endmodule

bind tick_timer_bank tick_timer_bank_chk #(
  .N_TMR    (N_TMR),
  .CW       (CW),
  .PW       (PW),
  .AW       (AW),
  .IRQW     (IRQW),
  .IRQ_BASE (IRQ_BASE),
  .SEP_IRQ  (SEP_IRQ)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .rd_ld_bit (bus_rdata[2]),
  .irq_o     (irq_o),
  .psc_val   (psc_val),
  .psc_rld   (psc_rld),
  .en_v      (en_v),
  .ie_v      (ie_v),
  .pend_v    (pend_v),
  .cnt_flat  (cnt_flat)
);

// File: tb/tick_timer_bank_tb_top.sv
`timescale 1ns/1ps
module tick_timer_bank_tb_top;
  localparam int BASE = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_i, rdata_s;
  logic [15:0] irq_i, irq_s;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer_bank dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_i), .irq_o(irq_i)
  );

  tick_timer_bank #(.SEP_IRQ(0)) dut_s (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_s), .irq_o(irq_s)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = 32'(d);
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] di, output logic [31:0] ds);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 6'(a);
    @(posedge clk);
    @(negedge clk);
    di = rdata_i; ds = rdata_s;
    bus_req = 1'b0;
  endtask

  task automatic run_case(input int p, input int r, input int ch, input bit rl);
    int t;
    int ba;
    logic [31:0] di, ds;
    t  = (r + 1) * (p + 1);
    ba = 4 + 4 * ch;
    wr(1, p);
    wr(0, 255);
    wr(ba + 1, r);
    wr(ba, r);
    wr(ba + 2, 9 | (int'(rl) << 1));
    wr(0, p);
    for (int pass = 0; pass < 2; pass++) begin
      bit ok = 1'b1;
      logic [15:0] act = '0, exp = '0;
      for (int n = 1; n <= t; n++) begin
        bit fire;
        logic [15:0] ei, es;
        @(negedge clk);
        fire = (n == t) && (pass == 0 || rl);
        ei = fire ? (16'd1 << (BASE + ch)) : 16'd0;
        es = fire ? (16'd1 << BASE) : 16'd0;
        if (ok && irq_i != ei) begin ok = 1'b0; act = irq_i; exp = ei; end
        if (ok && irq_s != es) begin ok = 1'b0; act = irq_s; exp = es; end
      end
      if (pass == 0) chk(ok, $sformatf("R5 R11 first underflow p=%0d r=%0d ch=%0d", p, r, ch), act, exp);
      else if (rl)   chk(ok, $sformatf("R6 repeat p=%0d r=%0d ch=%0d", p, r, ch), act, exp);
      else           chk(ok, $sformatf("R7 no repeat p=%0d r=%0d ch=%0d", p, r, ch), act, exp);
    end
    rd(ba + 2, di, ds);
    if (rl) chk(di == 32'h1B && ds == 32'h1B, "R6 R9 ctl running", di, 32'h1B);
    else begin
      chk(di == 32'h18 && ds == 32'h18, "R7 R9 ctl stopped", di, 32'h18);
      rd(ba, di, ds);
      chk(di == 0 && ds == 0, "R7 count at zero", di, 0);
    end
    wr(ba + 2, 32'h10);
    rd(ba + 2, di, ds);
    chk(di == 0 && ds == 0, "R9 pending cleared", di, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] di, ds;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    chk(irq_i == 0 && irq_s == 0, "R2 irq low", irq_i, 0);
    rd(4, di, ds);  chk(di == 0, "R2 ch0 count", di, 0);
    rd(5, di, ds);  chk(di == 0, "R2 ch0 reload", di, 0);
    rd(6, di, ds);  chk(di == 0, "R2 ch0 ctl", di, 0);
    rd(1, di, ds);  chk(di == 0, "R2 psc reload", di, 0);

    // R1 configuration word
    rd(2, di, ds);
    chk(di == 32'h11C, "R1 cfg per-timer", di, 32'h11C);
    chk(ds == 32'h01C, "R1 cfg shared", ds, 32'h01C);

    // R3 prescaler count readback
    wr(0, 200);
    rd(0, di, ds);
    chk(di == 200, "R3 psc readback", di, 200);

    // R4 hold and decrement (prescaler ticking every clock)
    wr(1, 0);
    wr(0, 0);
    wr(12, 7);
    wr(14, 0);
    repeat (20) @(negedge clk);
    rd(12, di, ds);
    chk(di == 7, "R4 hold while disabled", di, 7);
    wr(14, 1);
    repeat (3) @(negedge clk);
    rd(12, di, ds);
    chk(di == 4, "R4 decrement per tick", di, 4);
    wr(14, 0);
    repeat (10) @(negedge clk);
    rd(12, di, ds);
    chk(di == 3, "R4 hold after disable", di, 3);

    // R8 load strobe
    wr(17, 9);
    wr(18, 4);
    rd(16, di, ds);
    chk(di == 9, "R8 load copies reload", di, 9);
    rd(18, di, ds);
    chk(di == 0, "R8 load bit reads zero", di, 0);
    wr(16, 4);
    wr(18, 0);
    rd(16, di, ds);
    chk(di == 4, "R8 zero load bit ignored", di, 4);

    // R9 pending kept by writing zero, cleared by writing one
    wr(5, 0);
    wr(4, 0);
    wr(6, 9);
    repeat (3) @(negedge clk);
    rd(6, di, ds);
    chk(di == 32'h18, "R9 pending set", di, 32'h18);
    wr(6, 0);
    rd(6, di, ds);
    chk(di == 32'h10, "R9 pending kept on zero", di, 32'h10);
    wr(6, 32'h10);
    rd(6, di, ds);
    chk(di == 0, "R9 pending cleared on one", di, 0);

    // R10 underflow without interrupt enable
    begin
      bit ok = 1'b1;
      wr(9, 1);
      wr(8, 1);
      wr(10, 1);
      for (int n = 0; n < 8; n++) begin
        @(negedge clk);
        if (irq_i != 0 || irq_s != 0) ok = 1'b0;
      end
      chk(ok, "R10 no irq without enable", irq_i, 0);
      rd(10, di, ds);
      chk(di == 0, "R10 stopped, no pending", di, 0);
    end

    // R5 R6 R7 R11 sweep over channels, prescaler and timer reloads, modes
    for (int ch = 0; ch < 4; ch++)
      for (int pi = 0; pi < 3; pi++)
        for (int r = 0; r <= 2; r += 2)
          for (int m = 0; m < 2; m++)
            run_case((pi == 2) ? 3 : pi, r, ch, m[0]);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule